// File: doc/BRIEF.md
# Sixteen-bit timer with one software output-compare channel

The block is a 16-bit up-counter for a small microcontroller-style bus. Software reaches it through a byte-wide register port with six addresses. A control register picks the counter clock and a divide ratio. The counter runs from the system clock through a power-of-two prescaler. It wraps from 0xFFFF to 0 and raises an overflow event on the wrap. A single channel works in software output-compare mode. When the counter takes a new value equal to the 16-bit compare register, the channel raises its event flag. Each flag drives its own interrupt line when its enable bit is set.

Each event flag is cleared by a two-step handshake, run by a three-state machine per flag:
- **FLG_IDLE**: the flag is clear. An event moves it to FLG_PEND.
- **FLG_PEND**: the flag is set and not armed. A read of its register moves it to FLG_ARMED. Every other access keeps it in FLG_PEND.
- **FLG_ARMED**: the flag was read while set.
  - A write of 0 to the flag bit moves it to FLG_IDLE, which clears the flag.
  - These move it back to FLG_PEND: a write of 1 to the flag bit, an access to any other address, or a new event.
  - A further read of the same register keeps it in FLG_ARMED.
- A bit-clear done as read-modify-write therefore clears the flag. A blind byte write does not.

A second two-state machine gives coherent counter reads:
- **LAT_LIVE**: the low counter byte reads live. A read of the high byte moves it to LAT_HELD and captures the low byte.
- **LAT_HELD**: a read of the low byte returns the captured byte and moves it back to LAT_LIVE. Another high-byte read recaptures the low byte.

Top module: `cmp_timer`

## Requirements
- R1: After reset, every address (0 to 5) reads 0x00, and both interrupt outputs are low.
- R2: Address 0 is the control register, laid out as follows.
  - Bits 2:0: prescaler select (PS).
  - Bits 4:3: clock select. Only the value 01 advances the counter, on the system clock. 00, 10 and 11 hold the counter.
  - Bit 5: centre-mode select.
  - Bit 6: overflow interrupt enable.
  - Bit 7: overflow flag.
- R3: While running, the counter advances once every 2^PS enabled clock cycles, for PS from 0 to 7. Starting from reset, a run of K enabled cycles leaves the count at K >> PS.
- R4: The counter wraps from 0xFFFF to 0x0000. The overflow flag sets on the same edge as the wrap. `ovf_irq` is high while the flag and its enable (bit 6) are both 1.
- R5: Address 3 is the channel register, laid out as follows.
  - Bit 2: edge select A.
  - Bit 3: edge select B.
  - Bit 4: mode A.
  - Bit 5: mode B.
  - Bit 6: channel interrupt enable.
  - Bit 7: channel flag.
  - Bits 1:0 read 0.

  With mode B:A = 01 and centre mode off, the flag sets on the edge where the counter becomes equal to the compare value. `ch_irq` is high while the flag and bit 6 are both 1.
- R6: A flag clears only through this sequence: a read of its register while the flag is set, then a write with that bit 0, with no other access between them. Idle cycles between the two are allowed.
- R7: A write of 0 to a flag bit that is not preceded by such a read leaves the flag set.
- R8: An access to any other address between the arming read and the clearing write cancels the clear.
- R9: A new event after the arming read cancels the clear, so the flag stays set.
- R10: Writing 1 to a flag bit neither sets nor clears the flag. The other bits of that register still take the written value.
- R11: Addresses 1 and 2 read the counter high and low bytes. Reading address 1 captures the low byte. The next read of address 2 returns that captured byte, and later reads of address 2 return the live value.
- R12: Addresses 4 and 5 hold the compare high and low bytes. A write to address 4 is buffered and only takes effect, together with the low byte, when address 5 is written.
- R13: No channel flag is raised on a match when mode B:A is not 01 or when centre mode (address 0 bit 5) is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access; side effects occur at the clock edge |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| ovf_irq | output | 1 | Overflow interrupt request |
| ch_irq | output | 1 | Channel interrupt request |

## Verification
The assertions check these properties on every cycle:
- A stopped counter holds its value, and a changing counter steps by exactly one.
- The overflow flag rises only on the edge where the count becomes zero.
- The channel flag rises only when the new count equals the compare value.
- A flag falls only out of the armed state, on a write of 0 to its own address.
- An access to a foreign address disarms the channel clear.

Only the bench scenarios can show the rest:
- The prescaler ratios as final counts.
- The exact cycle of a match or a wrap.
- The coherent-read and compare buffering effects as read data.
- That a blind write, an intervening access, or a new event leaves the interrupt line high.

// File: rtl/cmpt_pkg.sv
package cmpt_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_CNTH  = 3'd1;
    localparam logic [ADDR_W-1:0] A_CNTL  = 3'd2;
    localparam logic [ADDR_W-1:0] A_CHCTL = 3'd3;
    localparam logic [ADDR_W-1:0] A_CMPH  = 3'd4;
    localparam logic [ADDR_W-1:0] A_CMPL  = 3'd5;

    localparam int FLAG_BIT = 7;
    localparam int IE_BIT   = 6;

    localparam int NUM_FLAGS = 2;
    localparam int FLG_OVF   = 0;
    localparam int FLG_CH    = 1;

    typedef enum logic [1:0] {
        FLG_IDLE  = 2'd0,
        FLG_PEND  = 2'd1,
        FLG_ARMED = 2'd2
    } flg_state_e;

    typedef enum logic {
        LAT_LIVE = 1'b0,
        LAT_HELD = 1'b1
    } lat_state_e;

    function automatic logic [ADDR_W-1:0] flag_addr(input int idx);
        return (idx == FLG_OVF) ? A_CTRL : A_CHCTL;
    endfunction
endpackage

// File: rtl/cmpt_prescaler.sv
module cmpt_prescaler #(
    parameter int PS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [PS_W-1:0] ps,
    output logic            tick
);
    localparam int DIV_W = (1 << PS_W) - 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W:0]   span;
    logic [DIV_W-1:0] limit;

    always_comb begin
        span  = ((DIV_W+1)'(1) << ps) - (DIV_W+1)'(1);
        limit = span[DIV_W-1:0];
        tick  = run && (div_q == limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (!run || tick) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/cmpt_counter.sv
module cmpt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cmp_en,
    input  logic [CNT_W-1:0] cmp,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap_evt,
    output logic             match_evt
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;

    always_comb begin
        cnt_nxt   = cnt_q + CNT_W'(1);
        wrap_evt  = tick && (cnt_q == {CNT_W{1'b1}});
        match_evt = tick && cmp_en && (cnt_nxt == cmp);
        cnt       = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_nxt;
        end
    end
endmodule

// File: rtl/cmpt_flag_fsm.sv
module cmpt_flag_fsm
    import cmpt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic rd_hit,
    input  logic wr_hit,
    input  logic wr_bit,
    input  logic other_acc,
    output logic flag,
    output logic armed
);
    flg_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLG_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_IDLE: begin
                if (evt) state_d = FLG_PEND;
            end
            FLG_PEND: begin
                if (evt)         state_d = FLG_PEND;
                else if (rd_hit) state_d = FLG_ARMED;
            end
            FLG_ARMED: begin
                if (evt)            state_d = FLG_PEND;
                else if (wr_hit)    state_d = wr_bit ? FLG_PEND : FLG_IDLE;
                else if (other_acc) state_d = FLG_PEND;
                else                state_d = FLG_ARMED;
            end
            default: state_d = FLG_IDLE;
        endcase
    end

    always_comb begin
        flag  = (state_q != FLG_IDLE);
        armed = (state_q == FLG_ARMED);
    end
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
    import cmpt_pkg::*;
#(
    parameter int PS_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic              ovf_irq,
    output logic              ch_irq
);
    localparam int CNT_W = 2 * BYTE_W;

    // control fields
    logic [PS_W-1:0]   ps_q;
    logic [1:0]        clk_sel_q;
    logic              cpwm_q;
    logic              ovf_ie_q;
    logic              els_a_q, els_b_q, ms_a_q, ms_b_q, ch_ie_q;
    logic [CNT_W-1:0]  cmp_q;
    logic [BYTE_W-1:0] cmp_buf_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] lat_lo_q;

    lat_state_e lat_q, lat_d;

    logic run, tick, oc_mode, wrap_evt, match_evt;
    logic [NUM_FLAGS-1:0] evt_w, flag_w, armed_w;
    logic acc;

    assign acc     = rd_en | wr_en;
    assign run     = (clk_sel_q == 2'b01);
    assign oc_mode = ({ms_b_q, ms_a_q} == 2'b01) && !cpwm_q;

    // register writes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ps_q      <= '0;
            clk_sel_q <= '0;
            cpwm_q    <= 1'b0;
            ovf_ie_q  <= 1'b0;
            els_a_q   <= 1'b0;
            els_b_q   <= 1'b0;
            ms_a_q    <= 1'b0;
            ms_b_q    <= 1'b0;
            ch_ie_q   <= 1'b0;
            cmp_q     <= '0;
            cmp_buf_q <= '0;
        end else if (wr_en) begin
            case (addr)
                A_CTRL: begin
                    ps_q      <= wdata[PS_W-1:0];
                    clk_sel_q <= wdata[4:3];
                    cpwm_q    <= wdata[5];
                    ovf_ie_q  <= wdata[IE_BIT];
                end
                A_CHCTL: begin
                    els_a_q <= wdata[2];
                    els_b_q <= wdata[3];
                    ms_a_q  <= wdata[4];
                    ms_b_q  <= wdata[5];
                    ch_ie_q <= wdata[IE_BIT];
                end
                A_CMPH: cmp_buf_q <= wdata;
                A_CMPL: cmp_q     <= {cmp_buf_q, wdata};
                default: ;
            endcase
        end
    end

    cmpt_prescaler #(.PS_W(PS_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .ps    (ps_q),
        .tick  (tick)
    );

    cmpt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .cmp_en    (oc_mode),
        .cmp       (cmp_q),
        .cnt       (cnt_q),
        .wrap_evt  (wrap_evt),
        .match_evt (match_evt)
    );

    assign evt_w[FLG_OVF] = wrap_evt;
    assign evt_w[FLG_CH]  = match_evt;

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        localparam logic [ADDR_W-1:0] MY_ADDR = flag_addr(g);
        logic hit;
        assign hit = (addr == MY_ADDR);
        cmpt_flag_fsm u_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .evt       (evt_w[g]),
            .rd_hit    (rd_en && !wr_en && hit),
            .wr_hit    (wr_en && hit),
            .wr_bit    (wdata[FLAG_BIT]),
            .other_acc (acc && !hit),
            .flag      (flag_w[g]),
            .armed     (armed_w[g])
        );
    end

    // coherent counter read state machine
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= LAT_LIVE;
        end else begin
            lat_q <= lat_d;
        end
    end

    always_comb begin
        lat_d = lat_q;
        unique case (lat_q)
            LAT_LIVE: if (rd_en && addr == A_CNTH) lat_d = LAT_HELD;
            LAT_HELD: if (rd_en && addr == A_CNTL) lat_d = LAT_LIVE;
            default:  lat_d = LAT_LIVE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_lo_q <= '0;
        end else if (rd_en && addr == A_CNTH) begin
            lat_lo_q <= cnt_q[BYTE_W-1:0];
        end
    end

    // read mux and interrupt outputs
    always_comb begin
        case (addr)
            A_CTRL:  rdata = {flag_w[FLG_OVF], ovf_ie_q, cpwm_q, clk_sel_q, ps_q};
            A_CNTH:  rdata = cnt_q[CNT_W-1:BYTE_W];
            A_CNTL:  rdata = (lat_q == LAT_HELD) ? lat_lo_q : cnt_q[BYTE_W-1:0];
            A_CHCTL: rdata = {flag_w[FLG_CH], ch_ie_q, ms_b_q, ms_a_q, els_b_q, els_a_q, 2'b00};
            A_CMPH:  rdata = cmp_q[CNT_W-1:BYTE_W];
            A_CMPL:  rdata = cmp_q[BYTE_W-1:0];
            default: rdata = '0;
        endcase
        ovf_irq = flag_w[FLG_OVF] && ovf_ie_q;
        ch_irq  = flag_w[FLG_CH] && ch_ie_q;
    end
endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk
    import cmpt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic              rd_en,
    input logic [BYTE_W-1:0] wdata,
    input logic              run,
    input logic [15:0]       cnt,
    input logic [15:0]       cmp,
    input logic [1:0]        flags,
    input logic [1:0]        armed
);
    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(cnt)); // R2

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cnt) |-> cnt == 16'($past(cnt) + 16'd1)); // R3

    AST_OVF_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[FLG_OVF]) |-> cnt == 16'd0); // R4

    AST_MATCH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[FLG_CH]) |-> cnt == $past(cmp)); // R5

    AST_CH_CLEAR_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flags[FLG_CH]) |-> ($past(armed[FLG_CH]) && $past(wr_en)
            && $past(addr) == A_CHCTL && !$past(wdata[FLAG_BIT]))); // R6

    AST_OVF_NO_BLIND: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flags[FLG_OVF]) |-> $past(armed[FLG_OVF])); // R7

    AST_FOREIGN_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
        (armed[FLG_CH] && (rd_en || wr_en) && addr != A_CHCTL) |=> !armed[FLG_CH]); // R8
endmodule

bind cmp_timer cmp_timer_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (addr),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .wdata (wdata),
    .run   (run),
    .cnt   (cnt_q),
    .cmp   (cmp_q),
    .flags (flag_w),
    .armed (armed_w)
);

// File: tb/cmp_timer_bench.sv
module cmp_timer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       ovf_irq, ch_irq;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    cmp_timer u_cmp_timer (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .ovf_irq(ovf_irq), .ch_irq(ch_irq)
    );

    // {clock select, prescaler, enabled cycles after start, expected count}
    localparam logic [36:0] VEC [8] = '{
        {2'd1, 3'd0, 16'd10,  16'd11},
        {2'd1, 3'd0, 16'd0,   16'd1},
        {2'd1, 3'd1, 16'd9,   16'd5},
        {2'd1, 3'd2, 16'd19,  16'd5},
        {2'd1, 3'd3, 16'd30,  16'd3},
        {2'd1, 3'd7, 16'd300, 16'd2},
        {2'd2, 3'd0, 16'd10,  16'd0},
        {2'd3, 3'd0, 16'd10,  16'd0}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] hi, lo;
        idle(1);
        do_reset();

        // R1: reset state
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), lo);
            chk("R1 reset read", {8'h0, lo}, 16'h0000);
        end
        chk("R1 irqs low", {14'd0, ovf_irq, ch_irq}, 16'd0);

        // R2 / R3: table of clock select and prescaler runs
        for (int i = 0; i < 8; i++) begin
            do_reset();
            wr(3'd0, {3'b000, VEC[i][36:35], VEC[i][34:32]});
            idle(int'(VEC[i][31:16]));
            wr(3'd0, 8'h00);
            rd(3'd1, hi);
            rd(3'd2, lo);
            chk(VEC[i][36:35] == 2'd1 ? "R3 prescaled count" : "R2 stopped count",
                {hi, lo}, VEC[i][15:0]);
        end

        // R4 / R7 / R10 / R6 on the overflow flag
        do_reset();
        wr(3'd0, 8'h48);
        idle(65535);
        chk("R4 no overflow before wrap", {15'd0, ovf_irq}, 16'd0);
        idle(1);
        chk("R4 overflow irq on wrap", {15'd0, ovf_irq}, 16'd1);
        wr(3'd0, 8'h40);
        chk("R7 blind write keeps overflow flag", {15'd0, ovf_irq}, 16'd1);
        wr(3'd0, 8'hC0);
        rd(3'd0, lo);
        chk("R10 write one keeps flag", {8'h0, lo}, 16'h00C0);
        wr(3'd0, 8'h40);
        chk("R6 read then write zero clears", {15'd0, ovf_irq}, 16'd0);
        wr(3'd0, 8'hC0);
        rd(3'd0, lo);
        chk("R10 write one does not set", {8'h0, lo}, 16'h0040);

        // R5 / R7 / R8 / R6 / R12 on the channel
        do_reset();
        wr(3'd4, 8'h00);
        wr(3'd5, 8'd20);
        wr(3'd3, 8'h50);
        wr(3'd0, 8'h08);
        idle(19);
        chk("R5 no flag before match", {15'd0, ch_irq}, 16'd0);
        idle(1);
        chk("R5 flag on match", {15'd0, ch_irq}, 16'd1);
        wr(3'd3, 8'h50);
        chk("R7 blind channel write", {15'd0, ch_irq}, 16'd1);
        rd(3'd3, lo);
        chk("R5 channel readback", {8'h0, lo}, 16'h00D0);
        rd(3'd0, lo);
        wr(3'd3, 8'h50);
        chk("R8 foreign access disarms", {15'd0, ch_irq}, 16'd1);
        rd(3'd3, lo);
        idle(2);
        wr(3'd3, 8'h50);
        chk("R6 channel clear", {15'd0, ch_irq}, 16'd0);
        rd(3'd3, lo);
        chk("R6 channel readback after clear", {8'h0, lo}, 16'h0050);
        wr(3'd4, 8'hAB);
        rd(3'd4, hi);
        chk("R12 high byte buffered", {8'h0, hi}, 16'h0000);
        wr(3'd5, 8'hCD);
        rd(3'd4, hi);
        rd(3'd5, lo);
        chk("R12 compare committed", {hi, lo}, 16'hABCD);

        // R9: new match after the arming read
        do_reset();
        wr(3'd5, 8'd5);
        wr(3'd3, 8'h50);
        wr(3'd0, 8'h08);
        idle(5);
        chk("R9 first match", {15'd0, ch_irq}, 16'd1);
        wr(3'd4, 8'h00);
        wr(3'd5, 8'd12);
        rd(3'd3, lo);
        idle(4);
        wr(3'd3, 8'h50);
        chk("R9 new event keeps flag", {15'd0, ch_irq}, 16'd1);

        // R11: coherent counter read
        do_reset();
        wr(3'd0, 8'h08);
        idle(299);
        rd(3'd1, hi);
        chk("R11 high byte", {8'h0, hi}, 16'h0001);
        idle(3);
        rd(3'd2, lo);
        chk("R11 captured low byte", {8'h0, lo}, 16'h002B);
        rd(3'd2, lo);
        chk("R11 live low byte", {8'h0, lo}, 16'h0030);

        // R13: no flag outside output-compare mode
        do_reset();
        wr(3'd5, 8'd3);
        wr(3'd3, 8'h40);
        wr(3'd0, 8'h08);
        idle(10);
        rd(3'd3, lo);
        chk("R13 mode 00 gives no flag", {8'h0, lo}, 16'h0040);
        do_reset();
        wr(3'd5, 8'd3);
        wr(3'd3, 8'h50);
        wr(3'd0, 8'h28);
        idle(10);
        chk("R13 centre mode gives no flag", {15'd0, ch_irq}, 16'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule